// File: doc/BRIEF.md
# Per-Instruction Stride Stream Prefetch Table

This block watches the demand accesses of a cache and learns, separately for each load or store instruction, whether that instruction walks memory with a steady step. Each instruction is identified by its program counter. The counter selects a set of a small set-associative table, and the full counter value is held as the tag. An entry keeps the last address the instruction touched, the secure attribute of that access and a small saturating confidence count.

The first sighting of an instruction claims an entry. The set's invalid ways are used before its least recently used way. Each later sighting with a new address counts up the confidence and computes the step as new address minus stored address. Once the confidence is high enough, the block emits a burst of prefetch addresses one step, two steps and so on ahead of the current access. The burst is written into a small output FIFO at one address per cycle. The access port drops its ready signal until the whole burst has entered the FIFO. A consumer pops the FIFO with a valid/ready handshake.

Top module: `stride_stream_table`

## Requirements
- R1: An accepted access with `acc_pc_ok` low changes no table state and issues no prefetch. The next access from the same instruction sees the entry exactly as it was before.
- R2: An accepted access whose program counter hits no valid way of its set allocates an entry. The entry holds the program counter, the address, the secure bit and a confidence count of zero. No prefetch is issued. Sets are selected by `acc_pc` bits [IDX_LSB +: log2(SETS)], which is bits [3:2] by default.
- R3: A hit whose address differs from the stored address increments the confidence count. A burst is issued only when the incremented count is at least THRESH (default 2). The burst therefore starts on the third distinct address of an instruction.
- R4: A burst carries DIST addresses (default 3) in the order new + d, new + 2d, new + 3d and so on. The step d is new address minus stored address, taken modulo 2^ADDR_W, so a step toward lower addresses works.
- R5: After a hit with a differing address, the stored address and the stored secure bit are replaced by those of the new access. The next step is measured from this new address.
- R6: A hit whose address equals the stored address leaves the count, the address and the secure bit unchanged and issues no prefetch.
- R7: The confidence count saturates at 2^CNT_W-1 (3 by default) instead of wrapping. An instruction that keeps streaming keeps firing.
- R8: Every prefetch of a burst presents on `pf_secure` the secure bit that the triggering access stored in the entry.
- R9: From the cycle after a burst-triggering access is accepted, `acc_ready` stays low until every address of the burst has entered the output FIFO. When `pf_ready` holds the FIFO full, `acc_ready` stays low and the head address is held.
- R10: On allocation, the lowest-numbered invalid way of the set is used first. If no way is invalid, the least recently allocated-or-hit way is replaced. Every allocation and every hit, with an equal or a differing address, marks the way as most recent.
- R11: After reset, `pf_valid` is low, `acc_ready` is high and every entry is invalid, so the first access of any instruction is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A demand access is presented |
| acc_ready | output | 1 | The block can take an access this cycle |
| acc_pc_ok | input | 1 | The access carries a meaningful program counter |
| acc_pc | input | PC_W | Program counter of the accessing instruction |
| acc_addr | input | ADDR_W | Accessed byte address |
| acc_secure | input | 1 | Secure attribute of the access |
| pf_valid | output | 1 | A prefetch address is at the FIFO head |
| pf_ready | input | 1 | The consumer takes the head prefetch |
| pf_addr | output | ADDR_W | Prefetch address |
| pf_secure | output | 1 | Secure attribute of the prefetch |

## Verification
The bench aims at the confidence count crossing the threshold and at saturation. A count that wraps would stop firing on the fifth distinct address. A negative step is also exercised, and a design that mishandles it would emit addresses far above the stream. Access with an equal address and access with an invalid program counter are each followed by an access whose expected step only matches if nothing was touched. Replacement is driven with three instructions sharing one set, so that evicting the wrong way fires a burst one access too early or misses where a hit is expected. Back-pressure on the FIFO checks that ready stays low and that the head is held, and a reset in the middle of the run checks that learned entries are gone.

// File: rtl/sst_pkg.sv
package sst_pkg;

   // What an accepted access does to the table
   typedef enum logic [1:0] {
      OP_IGNORE = 2'd0,
      OP_ALLOC  = 2'd1,
      OP_SAME   = 2'd2,
      OP_STEP   = 2'd3
   } sst_op_e;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sst_lru.sv
module sst_lru #(
   parameter int WAYS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    touch,
   input  logic [$clog2(WAYS)-1:0] touch_way,
   input  logic [WAYS-1:0]         valid_vec,
   output logic [$clog2(WAYS)-1:0] victim
);
   localparam int WAY_W = $clog2(WAYS);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   // Age rank per way: 0 is most recent, WAYS-1 is the replacement candidate
   logic [WAY_W-1:0] age [WAYS];
   logic [WAY_W-1:0] ref_age;
   logic [WAYS-1:0]  oldest;

   assign ref_age = age[touch_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) age[w] <= WAY_W'(w);
      end else if (touch) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)  age[w] <= '0;
            else if (age[w] < ref_age)   age[w] <= age[w] + 1'b1;
         end
      end
   end

   always_comb begin
      for (int w = 0; w < WAYS; w++) oldest[w] = (age[w] == OLDEST);
   end

   // Invalid ways first (lowest index), otherwise the oldest way
   always_comb begin
      logic found;
      found  = 1'b0;
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!valid_vec[w] && !found) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
      if (!found) begin
         for (int w = 0; w < WAYS; w++) begin
            if (oldest[w]) victim = WAY_W'(w);
         end
      end
   end

   AST_LRU_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1);  // R10

endmodule

// File: rtl/sst_table.sv
module sst_table
   import sst_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int ADDR_W  = 32,
   parameter int SETS    = 4,
   parameter int WAYS    = 2,
   parameter int CNT_W   = 2,
   parameter int THRESH  = 2,
   parameter int IDX_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic              lk_pc_ok,
   input  logic [PC_W-1:0]   lk_pc,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_secure,
   output logic              lk_fire,
   output logic [ADDR_W-1:0] lk_delta,
   output logic              src_secure
);
   localparam int IDX_W   = $clog2(SETS);
   localparam int WAY_W   = $clog2(WAYS);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic [WAYS-1:0]   ent_valid [SETS];
   logic [WAYS-1:0]   ent_sec   [SETS];
   logic [PC_W-1:0]   ent_tag   [SETS][WAYS];
   logic [ADDR_W-1:0] ent_addr  [SETS][WAYS];
   logic [CNT_W-1:0]  ent_cnt   [SETS][WAYS];

   logic [IDX_W-1:0]  set_idx;
   logic [WAYS-1:0]   hit_vec;
   logic [WAY_W-1:0]  hit_way;
   logic [WAY_W-1:0]  wr_way;
   logic [WAY_W-1:0]  victim_w [SETS];
   logic [SETS-1:0]   set_touch;
   logic [ADDR_W-1:0] old_addr;
   logic [CNT_W-1:0]  old_cnt;
   logic [CNT_W-1:0]  cnt_new;
   sst_op_e           op;

   logic [IDX_W-1:0]  fire_set;
   logic [WAY_W-1:0]  fire_way;

   assign set_idx = lk_pc[IDX_LSB +: IDX_W];

   always_comb begin
      for (int w = 0; w < WAYS; w++)
         hit_vec[w] = ent_valid[set_idx][w] && (ent_tag[set_idx][w] == lk_pc);
   end

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign wr_way   = (hit_vec != '0) ? hit_way : victim_w[set_idx];
   assign old_addr = ent_addr[set_idx][hit_way];
   assign old_cnt  = ent_cnt[set_idx][hit_way];
   assign cnt_new  = (old_cnt == CNT_W'(CNT_MAX)) ? old_cnt : old_cnt + 1'b1;

   always_comb begin
      if (!lk_pc_ok)                op = OP_IGNORE;
      else if (hit_vec == '0)       op = OP_ALLOC;
      else if (old_addr == lk_addr) op = OP_SAME;
      else                          op = OP_STEP;
   end

   assign lk_fire  = lk_en && (op == OP_STEP) && (cnt_new >= CNT_W'(THRESH));
   assign lk_delta = lk_addr - old_addr;

   // One replacement tracker per set
   for (genvar s = 0; s < SETS; s++) begin : g_set
      assign set_touch[s] = lk_en && (op != OP_IGNORE) && (set_idx == IDX_W'(s));
      sst_lru #(.WAYS(WAYS)) u_lru (
         .clk       (clk),
         .rst_n     (rst_n),
         .touch     (set_touch[s]),
         .touch_way (wr_way),
         .valid_vec (ent_valid[s]),
         .victim    (victim_w[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            ent_valid[s] <= '0;
            ent_sec[s]   <= '0;
            for (int w = 0; w < WAYS; w++) begin
               ent_tag[s][w]  <= '0;
               ent_addr[s][w] <= '0;
               ent_cnt[s][w]  <= '0;
            end
         end
      end else if (lk_en) begin
         case (op)
            OP_ALLOC: begin
               ent_valid[set_idx][wr_way] <= 1'b1;
               ent_sec[set_idx][wr_way]   <= lk_secure;
               ent_tag[set_idx][wr_way]   <= lk_pc;
               ent_addr[set_idx][wr_way]  <= lk_addr;
               ent_cnt[set_idx][wr_way]   <= '0;
            end
            OP_STEP: begin
               ent_sec[set_idx][wr_way]   <= lk_secure;
               ent_addr[set_idx][wr_way]  <= lk_addr;
               ent_cnt[set_idx][wr_way]   <= cnt_new;
            end
            default: ;
         endcase
      end
   end

   // The burst reads the secure bit of the entry that fired; accesses are
   // stalled for the whole burst, so that entry cannot change meanwhile.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fire_set <= '0;
         fire_way <= '0;
      end else if (lk_fire) begin
         fire_set <= set_idx;
         fire_way <= wr_way;
      end
   end

   assign src_secure = ent_sec[fire_set][fire_way];

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));  // R10

   AST_ALLOC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && lk_pc_ok && hit_vec == '0) |-> !lk_fire);  // R2

   AST_SAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && lk_pc_ok && hit_vec != '0 && old_addr == lk_addr) |-> !lk_fire);  // R6

   AST_ALLOC_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en && lk_pc_ok && hit_vec == '0) |=> (ent_valid[$past(set_idx)] != '0));  // R2

endmodule

// File: rtl/sst_burst.sv
module sst_burst #(
   parameter int ADDR_W = 32,
   parameter int DIST   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_base,
   input  logic [ADDR_W-1:0] load_delta,
   input  logic              full,
   output logic              push,
   output logic [ADDR_W-1:0] push_addr,
   output logic              busy
);
   localparam int REM_W = $clog2(DIST + 1);

   logic [ADDR_W-1:0] cur;
   logic [ADDR_W-1:0] step;
   logic [REM_W-1:0]  remain;

   assign busy      = (remain != '0);
   assign push      = busy && !full;
   assign push_addr = cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur    <= '0;
         step   <= '0;
         remain <= '0;
      end else if (load) begin
         cur    <= load_base + load_delta;
         step   <= load_delta;
         remain <= REM_W'(DIST);
      end else if (push) begin
         cur    <= cur + step;
         remain <= remain - 1'b1;
      end
   end

   AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !load);  // R9

   AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && full) |=> ($stable(cur) && busy));  // R9

endmodule

// File: rtl/sst_fifo.sv
module sst_fifo #(
   parameter int WIDTH = 33,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W:0]   count;

   assign empty = (count == '0);
   assign full  = (count == (PTR_W+1)'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= wr_ptr + 1'b1;
         end
         if (pop) rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: ;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < (PTR_W+1)'(DEPTH)));  // R9

   AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !pop) |=> ($stable(dout) && !empty));  // R9

endmodule

// File: rtl/stride_stream_table.sv
module stride_stream_table
   import sst_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int ADDR_W     = 32,
   parameter int SETS       = 4,
   parameter int WAYS       = 2,
   parameter int CNT_W      = 2,
   parameter int THRESH     = 2,
   parameter int DIST       = 3,
   parameter int FIFO_DEPTH = 2,
   parameter int IDX_LSB    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic              acc_pc_ok,
   input  logic [PC_W-1:0]   acc_pc,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_secure,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr,
   output logic              pf_secure
);
   localparam int IDX_W  = $clog2(SETS);
   localparam int FIFO_W = ADDR_W + 1;

   // Elaboration-time parameter checks
   if (!is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (!is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (!is_pow2(FIFO_DEPTH) || FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (THRESH < 1 || THRESH > (1 << CNT_W) - 1) begin : g_bad_thresh
      $error("THRESH must lie between 1 and the counter maximum");
   end
   if (DIST < 1) begin : g_bad_dist
      $error("DIST must be at least 1");
   end
   if (IDX_LSB + IDX_W > PC_W) begin : g_bad_idx
      $error("set index field exceeds the program counter width");
   end

   logic              acc_take;
   logic              tbl_fire;
   logic [ADDR_W-1:0] tbl_delta;
   logic              tbl_secure;
   logic              bst_push;
   logic [ADDR_W-1:0] bst_addr;
   logic              bst_busy;
   logic              fifo_full;
   logic              fifo_empty;
   logic [FIFO_W-1:0] fifo_dout;

   assign acc_ready = !bst_busy;
   assign acc_take  = acc_valid && acc_ready;

   sst_table #(
      .PC_W(PC_W), .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
      .CNT_W(CNT_W), .THRESH(THRESH), .IDX_LSB(IDX_LSB)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_en      (acc_take),
      .lk_pc_ok   (acc_pc_ok),
      .lk_pc      (acc_pc),
      .lk_addr    (acc_addr),
      .lk_secure  (acc_secure),
      .lk_fire    (tbl_fire),
      .lk_delta   (tbl_delta),
      .src_secure (tbl_secure)
   );

   sst_burst #(.ADDR_W(ADDR_W), .DIST(DIST)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (tbl_fire),
      .load_base  (acc_addr),
      .load_delta (tbl_delta),
      .full       (fifo_full),
      .push       (bst_push),
      .push_addr  (bst_addr),
      .busy       (bst_busy)
   );

   sst_fifo #(.WIDTH(FIFO_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (bst_push),
      .din   ({tbl_secure, bst_addr}),
      .pop   (pf_valid && pf_ready),
      .dout  (fifo_dout),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   assign pf_valid  = !fifo_empty;
   assign pf_addr   = fifo_dout[ADDR_W-1:0];
   assign pf_secure = fifo_dout[ADDR_W];

   AST_IGNORE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_take && !acc_pc_ok) |=> !bst_busy);  // R1

   AST_FIRE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_take && tbl_fire) |=> !acc_ready);  // R9

endmodule

// File: tb/stride_stream_table_test.sv
module stride_stream_table_test;

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] addr;
      logic        ok;
      logic        sec;
      logic [1:0]  n;
      logic [31:0] delta;
   } vec_t;

   localparam int NV = 17;
   // A=0x100, B=0x110, C=0x120 all fall in set 0 (pc bits [3:2] = 0)
   localparam vec_t VEC [NV] = '{
      '{32'h100, 32'h1000, 1'b1, 1'b0, 2'd0, 32'h0},         // miss
      '{32'h100, 32'h1010, 1'b1, 1'b0, 2'd0, 32'h0},         // count 1
      '{32'h100, 32'h1020, 1'b1, 1'b1, 2'd3, 32'h10},        // count 2 fires
      '{32'h100, 32'h1020, 1'b1, 1'b0, 2'd0, 32'h0},         // same address
      '{32'h100, 32'h1000, 1'b1, 1'b1, 2'd3, 32'hFFFF_FFE0}, // negative step
      '{32'h100, 32'h1008, 1'b1, 1'b0, 2'd3, 32'h8},         // saturated
      '{32'h100, 32'h5000, 1'b0, 1'b1, 2'd0, 32'h0},         // no valid PC
      '{32'h100, 32'h1010, 1'b1, 1'b0, 2'd3, 32'h8},         // step from 0x1008
      '{32'h110, 32'h2000, 1'b1, 1'b0, 2'd0, 32'h0},         // B into invalid way
      '{32'h100, 32'h1018, 1'b1, 1'b1, 2'd3, 32'h8},         // A most recent
      '{32'h120, 32'h3000, 1'b1, 1'b0, 2'd0, 32'h0},         // C evicts B
      '{32'h110, 32'h2040, 1'b1, 1'b0, 2'd0, 32'h0},         // B misses, evicts A
      '{32'h110, 32'h2080, 1'b1, 1'b0, 2'd0, 32'h0},         // B count 1
      '{32'h110, 32'h20C0, 1'b1, 1'b0, 2'd3, 32'h40},        // B count 2 fires
      '{32'h120, 32'h3004, 1'b1, 1'b0, 2'd0, 32'h0},         // C survived, count 1
      '{32'h100, 32'h1020, 1'b1, 1'b0, 2'd0, 32'h0},         // A misses
      '{32'h100, 32'h1028, 1'b1, 1'b0, 2'd0, 32'h0}          // A count 1
   };

   function automatic string vtag(int i);
      case (i)
         0, 15:     return "R2/R11";
         1, 12, 16: return "R3";
         2, 13:     return "R3/R4";
         3:         return "R6";
         4:         return "R4/R5";
         5:         return "R7";
         6, 7:      return "R1";
         default:   return "R10";
      endcase
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_ready;
   logic        acc_pc_ok = 1'b0;
   logic [31:0] acc_pc = '0;
   logic [31:0] acc_addr = '0;
   logic        acc_secure = 1'b0;
   logic        pf_valid;
   logic        pf_ready = 1'b1;
   logic [31:0] pf_addr;
   logic        pf_secure;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] cap_addr [$];
   logic        cap_sec  [$];

   always #2 clk = ~clk;

   stride_stream_table uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_pc_ok(acc_pc_ok),
      .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_secure(acc_secure),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
      .pf_secure(pf_secure)
   );

   always @(negedge clk) begin
      if (rst_n && pf_valid && pf_ready) begin
         cap_addr.push_back(pf_addr);
         cap_sec.push_back(pf_secure);
      end
   end

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic send(logic [31:0] pc, logic [31:0] addr, logic ok, logic sec);
      @(negedge clk);
      while (!acc_ready) @(negedge clk);
      acc_pc = pc; acc_addr = addr; acc_pc_ok = ok; acc_secure = sec;
      acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic drain();
      int idle = 0;
      while (idle < 2) begin
         @(negedge clk);
         if (acc_ready && !pf_valid) idle++;
         else idle = 0;
      end
   endtask

   task automatic clear_cap();
      cap_addr.delete();
      cap_sec.delete();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(acc_ready == 1'b1, "R11", "acc_ready after reset", 32'(acc_ready), 32'h1);
      check(pf_valid == 1'b0, "R11", "pf_valid after reset", 32'(pf_valid), 32'h0);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         clear_cap();
         send(VEC[i].pc, VEC[i].addr, VEC[i].ok, VEC[i].sec);
         drain();
         check(cap_addr.size() == int'(VEC[i].n), vtag(i),
               $sformatf("prefetch count, vector %0d", i),
               32'(cap_addr.size()), 32'(VEC[i].n));
         for (int k = 0; k < int'(VEC[i].n); k++) begin
            logic [31:0] exp_a;
            exp_a = VEC[i].addr + VEC[i].delta * 32'(k + 1);
            if (k < cap_addr.size()) begin
               check(cap_addr[k] == exp_a, "R4",
                     $sformatf("prefetch %0d address, vector %0d", k, i), cap_addr[k], exp_a);
               check(cap_sec[k] == VEC[i].sec, "R8",
                     $sformatf("prefetch %0d secure, vector %0d", k, i),
                     32'(cap_sec[k]), 32'(VEC[i].sec));
            end
         end
      end

      // Back-pressure: D=0x204 lives in set 1
      send(32'h204, 32'h4000, 1'b1, 1'b0);
      drain();
      send(32'h204, 32'h4100, 1'b1, 1'b0);
      drain();
      clear_cap();
      pf_ready = 1'b0;
      send(32'h204, 32'h4200, 1'b1, 1'b1);
      repeat (6) @(negedge clk);
      check(acc_ready == 1'b0, "R9", "acc_ready while FIFO full", 32'(acc_ready), 32'h0);
      check(pf_valid == 1'b1, "R9", "pf_valid while stalled", 32'(pf_valid), 32'h1);
      check(pf_addr == 32'h4300, "R9", "head held while stalled", pf_addr, 32'h4300);
      check(pf_secure == 1'b1, "R8", "head secure while stalled", 32'(pf_secure), 32'h1);
      pf_ready = 1'b1;
      drain();
      check(cap_addr.size() == 3, "R9", "burst length after release", 32'(cap_addr.size()), 32'd3);
      for (int k = 0; k < 3; k++) begin
         logic [31:0] exp_a;
         exp_a = 32'h4200 + 32'h100 * 32'(k + 1);
         if (k < cap_addr.size())
            check(cap_addr[k] == exp_a, "R4", $sformatf("released prefetch %0d", k), cap_addr[k], exp_a);
      end
      check(acc_ready == 1'b1, "R9", "acc_ready after burst", 32'(acc_ready), 32'h1);

      // Reset in mid-run clears learned entries
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pf_valid == 1'b0, "R11", "pf_valid after second reset", 32'(pf_valid), 32'h0);
      check(acc_ready == 1'b1, "R11", "acc_ready after second reset", 32'(acc_ready), 32'h1);
      clear_cap();
      send(32'h204, 32'h4300, 1'b1, 1'b0);
      drain();
      send(32'h204, 32'h4400, 1'b1, 1'b0);
      drain();
      check(cap_addr.size() == 0, "R11", "no burst from a cleared entry", 32'(cap_addr.size()), 32'h0);

      finish_run();
   end

endmodule